// File: doc/BRIEF.md
# Interrupt Acceptance Timing Gate

This block sits between the pending-request logic and the CPU sequencer. In every clock state it decides whether a pending request may be taken. The request can be maskable or non-maskable. The decision does not come from a simple enable-and-mask test. It follows several timing rules:

- A new mask bit takes effect only after a delay.
- Acceptance is held off for a few states after the mask changes.
- Acceptance is held off in any state in which the controller's own registers are written.
- During a block transfer, the acceptance point and the stacked return address depend on the kind of transfer in progress.

When a request is taken, the gate raises a one-cycle accept pulse. In the same cycle it presents the return address that the sequencer must stack. The gate also drives the mask bit currently in force, so the sequencer can read it. Choosing a vector, arbitrating between sources, stacking and moving the transfer data all stay outside this block.

Top module: `irq_accept_gate`

## Requirements
- R1: Reset behaviour. While reset is held and in the first state after release, `accept` is 0, `mask_eff` is 1 and `ret_addr` is 0. All hold-off windows are clear after reset, so a request seen in the first state after release can already be granted.
- R2: Mask delay. When `mask_upd` is high in state c, `mask_eff` shows `mask_new` from state c+2 on. Before that, the old value governs masking. Updates in back-to-back states take effect in the order they were issued.
- R3: Mask-update hold-off. No request, non-maskable included, is granted in the state in which `mask_upd` is high or in any of the 3 states that follow.
- R4: Register-write hold-off. No request is granted in a state in which `ctl_wr` is high.
- R5: Masking. A maskable request (`irq_req`) is eligible only while `mask_eff` is 0. A non-maskable request (`nmi_req`) is eligible regardless of `mask_eff`.
- R6: Idle acceptance point. With `xfer_busy` low, a grant can happen only in a state with `insn_bound` high. The return address is then `next_pc`.
- R7: Byte-kind transfers. With `xfer_busy` high and `xfer_kind` equal to 2'b00 (byte) or 2'b11 (treated as byte), nothing is granted, non-maskable included. This holds even when `xfer_step_end` or `insn_bound` is high.
- R8: Word-kind transfers. With `xfer_busy` high and `xfer_kind` equal to 2'b01, a grant can happen only in a state with `xfer_step_end` high. The return address is then `next_pc`.
- R9: Resumable transfers. With `xfer_busy` high and `xfer_kind` equal to 2'b10, a grant can happen only in a state with `xfer_step_end` high. The return address is then `cur_pc`, so the transfer restarts after return.
- R10: Accept pulse. A grant made in state n appears as `accept`=1 in state n+1, with `ret_addr` updated in the same state. `accept` is never high in two consecutive states. `ret_addr` holds its value until the next grant.
- R11: Pending requests. A request that stays asserted while blocked is granted in the first state in which every rule above allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one state |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_upd | input | 1 | Pulse in the last state of a mask-modifying instruction |
| mask_new | input | 1 | Mask bit value written by that instruction |
| ctl_wr | input | 1 | Controller register write in this state |
| insn_bound | input | 1 | Instruction boundary in this state |
| xfer_busy | input | 1 | Block transfer in progress |
| xfer_kind | input | 2 | 00 byte, 01 word, 10 resumable, 11 treated as byte |
| xfer_step_end | input | 1 | Last state of one transfer cycle |
| cur_pc | input | ADDR_W | Address of the current instruction |
| next_pc | input | ADDR_W | Address of the following instruction |
| irq_req | input | 1 | Maskable request level |
| nmi_req | input | 1 | Non-maskable request level |
| accept | output | 1 | One-state accept pulse |
| ret_addr | output | ADDR_W | Return address to stack, valid with `accept` |
| mask_eff | output | 1 | Mask bit currently in force (1 = maskable requests blocked) |

## Verification
The bench builds the gate with a 16-bit address width, a mask delay of 2 and a hold-off span of 3, which are the timings the rules call for. With these values the short address lets the bench give `cur_pc` and `next_pc` distinct patterns. That separates the return-address choice of R9 from that of R6 and R8. The small delay and span also let a directed run cover many combinations: updates in back-to-back states, a hold-off that overlaps a register write, and a transfer that ends while a request waits. A long pseudo-random phase then mixes all inputs, and the model is compared in every state.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef enum logic [1:0] {
    XK_BYTE   = 2'b00,
    XK_WORD   = 2'b01,
    XK_RESUME = 2'b10,
    XK_RSVD   = 2'b11
  } xfer_kind_e;

  // A request is eligible when it is non-maskable or the mask is clear.
  function automatic logic req_eligible(logic nmi, logic irq, logic mask);
    return nmi | (irq & ~mask);
  endfunction

  // Whether this state is a permitted acceptance point.
  function automatic logic accept_point(logic busy, logic [1:0] kind,
                                        logic step_end, logic bound);
    logic ok;
    if (!busy) begin
      ok = bound;
    end else begin
      case (xfer_kind_e'(kind))
        XK_WORD, XK_RESUME: ok = step_end;
        default:            ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  // Resumable transfers return to the transfer instruction itself.
  function automatic logic pick_current(logic busy, logic [1:0] kind);
    return busy & (xfer_kind_e'(kind) == XK_RESUME);
  endfunction

endpackage

// File: rtl/irq_mask_delay.sv
module irq_mask_delay #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic new_val,
  output logic mask_eff
);

  generate
    if (DELAY <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n)   mask_eff <= 1'b1;
        else if (upd) mask_eff <= new_val;
      end
    end else begin : g_pipe
      localparam int STG = DELAY - 1;
      logic [STG-1:0] vld;
      logic [STG-1:0] val;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld[0] <= 1'b0;
          val[0] <= 1'b0;
        end else begin
          vld[0] <= upd;
          val[0] <= new_val;
        end
      end

      for (genvar i = 1; i < STG; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            vld[i] <= 1'b0;
            val[i] <= 1'b0;
          end else begin
            vld[i] <= vld[i-1];
            val[i] <= val[i-1];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n)            mask_eff <= 1'b1;
        else if (vld[STG-1])   mask_eff <= val[STG-1];
      end
    end
  endgenerate

endmodule

// File: rtl/irq_blackout.sv
module irq_blackout #(
  parameter int SPAN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  output logic active
);

  localparam int CW = $clog2(SPAN + 1);
  localparam logic [CW-1:0] LOAD = CW'(SPAN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (upd)            remain <= LOAD;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  // The update state itself and SPAN states after it are held off.
  assign active = upd | (remain != '0);

endmodule

// File: rtl/irq_accept_window.sv
module irq_accept_window
  import irq_gate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              busy,
  input  logic [1:0]        kind,
  input  logic              step_end,
  input  logic              bound,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              open,
  output logic [ADDR_W-1:0] ret
);

  always_comb begin
    open = accept_point(busy, kind, step_end, bound);
    ret  = pick_current(busy, kind) ? cur_pc : next_pc;
  end

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_gate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MASK_DELAY  = 2,
  parameter int HOLD_STATES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_upd,
  input  logic              mask_new,
  input  logic              ctl_wr,
  input  logic              insn_bound,
  input  logic              xfer_busy,
  input  logic [1:0]        xfer_kind,
  input  logic              xfer_step_end,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              irq_req,
  input  logic              nmi_req,
  output logic              accept,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              mask_eff
);

  // Named internal events, brought out for the checker.
  logic              blackout_act;
  logic              win_open;
  logic [ADDR_W-1:0] win_ret;
  logic              eligible;
  logic              grant;

  irq_mask_delay #(.DELAY(MASK_DELAY)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (mask_upd),
    .new_val  (mask_new),
    .mask_eff (mask_eff)
  );

  irq_blackout #(.SPAN(HOLD_STATES)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (mask_upd),
    .active (blackout_act)
  );

  irq_accept_window #(.ADDR_W(ADDR_W)) u_win (
    .busy     (xfer_busy),
    .kind     (xfer_kind),
    .step_end (xfer_step_end),
    .bound    (insn_bound),
    .cur_pc   (cur_pc),
    .next_pc  (next_pc),
    .open     (win_open),
    .ret      (win_ret)
  );

  assign eligible = req_eligible(nmi_req, irq_req, mask_eff);
  assign grant    = eligible & win_open & ~blackout_act & ~ctl_wr & ~accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept   <= 1'b0;
      ret_addr <= '0;
    end else begin
      accept <= grant;
      if (grant) ret_addr <= win_ret;
    end
  end

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       xfer_busy,
  input logic [1:0] xfer_kind,
  input logic       nmi_req,
  input logic       accept,
  input logic       mask_eff,
  input logic       blackout_act,
  input logic       grant
);

  // R3: a held-off state never leads to an accept.
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    blackout_act |=> !accept);

  // R4: a register write state never leads to an accept.
  a_r4_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !accept);

  // R7: byte-kind transfers accept nothing.
  a_r7_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && (xfer_kind == 2'b00 || xfer_kind == 2'b11)) |=> !accept);

  // R5: a grant without NMI requires the mask to be clear.
  a_r5_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !nmi_req) |-> !mask_eff);

  // R10: grant turns into accept one state later.
  a_r10_grant_to_accept: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> accept);

  // R10: accept is a one-state pulse.
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

endmodule

bind irq_accept_gate irq_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr       (ctl_wr),
  .xfer_busy    (xfer_busy),
  .xfer_kind    (xfer_kind),
  .nmi_req      (nmi_req),
  .accept       (accept),
  .mask_eff     (mask_eff),
  .blackout_act (blackout_act),
  .grant        (grant)
);

// File: tb/tb_irq_accept_gate.sv
module tb_irq_accept_gate;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MD = 2;
  localparam int HS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mask_upd = 0, mask_new = 0, ctl_wr = 0, insn_bound = 0;
  logic          xfer_busy = 0, xfer_step_end = 0, irq_req = 0, nmi_req = 0;
  logic [1:0]    xfer_kind = 2'b00;
  logic [AW-1:0] cur_pc = '0, next_pc = '0;
  logic          accept, mask_eff;
  logic [AW-1:0] ret_addr;

  irq_accept_gate #(.ADDR_W(AW), .MASK_DELAY(MD), .HOLD_STATES(HS)) dut (
    .clk(clk), .rst_n(rst_n), .mask_upd(mask_upd), .mask_new(mask_new),
    .ctl_wr(ctl_wr), .insn_bound(insn_bound), .xfer_busy(xfer_busy),
    .xfer_kind(xfer_kind), .xfer_step_end(xfer_step_end), .cur_pc(cur_pc),
    .next_pc(next_pc), .irq_req(irq_req), .nmi_req(nmi_req),
    .accept(accept), .ret_addr(ret_addr), .mask_eff(mask_eff)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state: scheduled mask changes, hold-off horizon.
  typedef struct { int at; bit v; } mchg_t;
  mchg_t         mq[$];
  int            n = 0;
  bit            m_mask = 1;
  int            hold_until = -1;
  bit            e_acc = 0;
  logic [AW-1:0] e_ret = '0;
  string         e_tag = "R1";
  bit            prev_req = 0;
  int unsigned   lfsr = 32'h1234_5678;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (state %0d)", tag, what, act, exp, n);
    end
  endtask

  task automatic clear_inputs();
    mask_upd = 0; mask_new = 0; ctl_wr = 0; insn_bound = 0;
    xfer_busy = 0; xfer_kind = 2'b00; xfer_step_end = 0;
    irq_req = 0; nmi_req = 0;
  endtask

  // One state: compare outputs, then decide the next state from the inputs.
  task automatic cycle();
    bit blk, open, elig, g;
    string why;
    while (mq.size() > 0 && mq[0].at <= n) begin
      m_mask = mq[0].v;
      void'(mq.pop_front());
    end
    chk(mask_eff === m_mask, "R2", "mask_eff", mask_eff, m_mask);
    chk(accept === e_acc, e_tag, "accept", accept, e_acc);
    chk(ret_addr === e_ret, e_tag, "ret_addr", ret_addr, e_ret);

    blk = 1; open = 0;
    if (mask_upd || n <= hold_until)  why = "R3 hold-off";
    else if (ctl_wr)                   why = "R4 reg write";
    else if (e_acc)                    why = "R10 pulse gap";
    else begin
      blk = 0;
      if (!xfer_busy) begin open = insn_bound; why = "R6 idle point"; end
      else if (xfer_kind == 2'b01) begin open = xfer_step_end; why = "R8 word step"; end
      else if (xfer_kind == 2'b10) begin open = xfer_step_end; why = "R9 resume step"; end
      else why = "R7 byte transfer";
    end
    elig = nmi_req || (irq_req && !m_mask);
    if (!nmi_req && irq_req) why = {why, " R5"};
    if (prev_req) why = {why, " R11"};
    g = !blk && open && elig;

    if (mask_upd) begin
      mq.push_back('{n + 2, mask_new});
      hold_until = n + 3;
    end
    prev_req = (nmi_req || irq_req) && !g;
    e_acc = g;
    e_tag = why;
    if (g) e_ret = (xfer_busy && xfer_kind == 2'b10) ? cur_pc : next_pc;

    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic run_idle(int k);
    for (int i = 0; i < k; i++) cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk);
    // R1: values under reset
    chk(accept === 1'b0, "R1", "accept in reset", accept, 0);
    chk(mask_eff === 1'b1, "R1", "mask_eff in reset", mask_eff, 1);
    chk(ret_addr === '0, "R1", "ret_addr in reset", ret_addr, 0);
    rst_n = 1;
    n = 0;

    // R1 / R6: NMI at boundary in the first state after reset
    cur_pc = 16'h1000; next_pc = 16'h1002;
    nmi_req = 1; insn_bound = 1; cycle();
    nmi_req = 0; insn_bound = 0; run_idle(2);

    // R5: masked irq ignored at boundaries while mask is set
    irq_req = 1; insn_bound = 1; run_idle(3);

    // R2 / R3 / R11: clear mask, irq waits through hold-off
    mask_upd = 1; mask_new = 0; cycle();
    mask_upd = 0; next_pc = 16'h2004; run_idle(7);
    irq_req = 0; insn_bound = 0; run_idle(2);

    // R4: register writes block an NMI at boundaries
    nmi_req = 1; insn_bound = 1; ctl_wr = 1; run_idle(3);
    ctl_wr = 0; run_idle(2);
    nmi_req = 0; insn_bound = 0; run_idle(1);

    // R7: byte transfer holds off even NMI
    cur_pc = 16'h3000; next_pc = 16'h3004;
    xfer_busy = 1; xfer_kind = 2'b00; nmi_req = 1; insn_bound = 1;
    for (int i = 0; i < 6; i++) begin xfer_step_end = i[0]; cycle(); end
    xfer_kind = 2'b11; run_idle(3);
    xfer_busy = 0; xfer_step_end = 0; cycle();
    nmi_req = 0; insn_bound = 0; run_idle(2);

    // R8: word transfer accepts at step end with next address
    cur_pc = 16'h4000; next_pc = 16'h4006;
    xfer_busy = 1; xfer_kind = 2'b01; irq_req = 1;
    run_idle(2);
    xfer_step_end = 1; cycle(); xfer_step_end = 0; run_idle(2);
    irq_req = 0; xfer_busy = 0; run_idle(1);

    // R9: resumable transfer returns to the transfer instruction
    cur_pc = 16'h5000; next_pc = 16'h5008;
    xfer_busy = 1; xfer_kind = 2'b10; nmi_req = 1;
    run_idle(1);
    xfer_step_end = 1; cycle(); xfer_step_end = 0; run_idle(2);
    nmi_req = 0; xfer_busy = 0; run_idle(1);

    // R2: back-to-back updates apply in order
    mask_upd = 1; mask_new = 1; cycle();
    mask_new = 0; cycle();
    mask_new = 1; cycle();
    mask_upd = 0; run_idle(5);

    // Mixed pseudo-random phase
    for (int i = 0; i < 4000; i++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      mask_upd      = (lfsr[3:0] == 4'h0);
      mask_new      = lfsr[4];
      ctl_wr        = (lfsr[8:6] == 3'h0);
      insn_bound    = lfsr[9];
      xfer_busy     = (lfsr[11:10] == 2'b00);
      xfer_kind     = lfsr[13:12];
      xfer_step_end = lfsr[14];
      irq_req       = lfsr[16] | lfsr[15];
      nmi_req       = (lfsr[19:17] == 3'h0);
      cur_pc        = lfsr[31:16];
      next_pc       = lfsr[31:16] + 16'h2;
      cycle();
    end
    clear_inputs();
    run_idle(6);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule